// File: doc/BRIEF.md
# Capture Delay Window Search Controller

This block calibrates where an ADC data bus is sampled. It steps a delay-tap setting upward from tap 0 through the last tap. For each tap it loads the setting into an external delay line: the value is presented first, then a load strobe follows. It then tests the I channel while Q is held at all ones, and tests Q the same way with the roles swapped. Each test clears the pattern checker and then enables it for a fixed dwell time. A tap counts as good only when both channel tests report lock with no errors.

Consecutive good taps form a window. When a bad tap ends a window, the search stops if the window spans at least four taps. A narrower window is dropped and the sweep carries on. If a sweep finds no qualifying window, the controller waits for a settle period and sweeps once more. When a window qualifies, its integer midpoint is loaded through the same value-then-strobe sequence. The controller then returns both channels to normal mode, turns the checker off and raises `done_o`. If no window qualifies, it instead reports one of two failures: no window at all, or a window that was too narrow.

Top module: `cdly_cal_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `done_o`, `fail_conv_o`, `fail_narrow_o`, `dly_load_o` and `chk_en_o` are 0, `dly_val_o` and `tap_o` are 0, and both mode outputs are 0 (normal).
- R2: Each load presents the tap on `dly_val_o` for one cycle before `dly_load_o` is high. The strobe is high for exactly one cycle, with `dly_val_o` unchanged. A sweep loads taps 0, 1, 2 and so on upward.
- R3: Each tap is tested twice, I first and Q second. In the I test, `mode_i_o`=1 (ramp) and `mode_q_o`=2 (all ones); the Q test swaps the two values. Each test has one cycle with `chk_en_o`=0, then exactly DWELL_CYC cycles with `chk_en_o`=1. The checker result is sampled in the last enabled cycle.
- R4: A tap passes only if both tests see `chk_lock_i`=1 and `chk_err_i`=0. A missing lock on either channel fails the tap.
- R5: A passing tap opens a window or extends the open one. When a failing tap closes a window with stop−start ≥ 4, the sweep ends. When stop−start < 4, the window is dropped and the sweep continues.
- R6: A window still open after the last tap is judged as though the next tap had failed.
- R7: If a sweep ends with no qualifying window and fewer than MAX_TRIES sweeps have run, the controller pauses PAUSE_CYC cycles with the checker off and then restarts at tap 0. Every `chk_en_o`=0 cycle from the last dwell to the new tap-0 strobe is counted, the strobe cycle included. That count is PAUSE_CYC+3.
- R8: On success, tap (start+stop)/2, rounded down, is loaded with the R2 sequence. In the next cycle `done_o`=1, `tap_o` equals that tap, and both failure flags are 0.
- R9: While `done_o`=1, both mode outputs are 0, and `chk_en_o` and `dly_load_o` are 0. `done_o` stays high until the next `start_i`.
- R10: After the final sweep fails, `done_o`=1 and `tap_o`=0, with no midpoint load. `fail_narrow_o`=1 if a window shorter than the limit is still open at the last tap; otherwise `fail_conv_o`=1. The two flags are never both set.
- R11: A `start_i` pulse while a search is running has no effect on that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a search when idle or finished |
| dly_val_o | output | TAP_W | Delay tap value to load |
| dly_load_o | output | 1 | One-cycle load strobe for the delay tap |
| chk_en_o | output | 1 | Pattern checker enable (low clears it) |
| mode_i_o | output | 2 | I channel test mode: 0 normal, 1 ramp, 2 all ones |
| mode_q_o | output | 2 | Q channel test mode: 0 normal, 1 ramp, 2 all ones |
| chk_lock_i | input | 1 | Checker has locked onto the ramp |
| chk_err_i | input | 1 | Checker has seen a deviation |
| done_o | output | 1 | Search finished (success or failure) |
| fail_conv_o | output | 1 | No passing window found |
| fail_narrow_o | output | 1 | Only a window narrower than the limit found |
| tap_o | output | TAP_W | Chosen midpoint tap (0 on failure) |

## Verification
Two decisions can land in the same evaluation cycle. One is extending a window at the last tap. The other is the end-of-sweep judgement, which then has to pick one of three outcomes: accept the window, retry, or report a narrow failure. The bench provokes this case with passing runs that reach the top tap, some wide enough to qualify and some not. It compares the chosen tap, the failure flags and the number of sweeps with a reference search written in the bench. The bench also sets up cases where a closing tap ends a window of exactly four taps and of three taps. It checks the load count and the order of the strobes, which shows that the sweep stops on the right tap.

// File: rtl/cdly_pkg.sv
package cdly_pkg;

  // Test-word selection driven to each ADC channel.
  typedef enum logic [1:0] {
    TM_NORMAL = 2'd0,
    TM_RAMP   = 2'd1,
    TM_ONES   = 2'd2
  } tmode_e;

  // Search sequencer states.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETV,
    ST_STRB,
    ST_CLR_I,
    ST_DWL_I,
    ST_CLR_Q,
    ST_DWL_Q,
    ST_EVAL,
    ST_PAUSE,
    ST_DONE
  } cal_st_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/cdly_timer.sv
// Down-counter shared by the dwell and the retry pause.
module cdly_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = load_val_i - CNT_W'(1);
      run_d  = 1'b1;
      cnt_en = 1'b1;
    end else if (run_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) begin
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/cdly_window.sv
// Tracks the current run of passing taps and judges it.
module cdly_window #(
  parameter int TAP_W    = 5,
  parameter int MIN_SPAN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic             last_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             found_o,
  output logic             narrow_o,
  output logic [TAP_W-1:0] sel_start_o,
  output logic [TAP_W-1:0] sel_stop_o
);

  localparam logic [TAP_W:0] MIN_W = (TAP_W+1)'(MIN_SPAN);

  logic             open_q;
  logic [TAP_W-1:0] start_q, stop_q;
  logic             reg_en;
  logic             open_d;
  logic [TAP_W-1:0] start_d, stop_d;
  logic [TAP_W:0]   closed_span, running_span;
  logic             closes_wide, ends_wide;

  // Window as it would look after this tap is folded in.
  always_comb begin
    sel_start_o  = open_q ? start_q : tap_i;
    sel_stop_o   = pass_i ? tap_i : stop_q;
    closed_span  = {1'b0, stop_q} - {1'b0, start_q};
    running_span = {1'b0, tap_i} - {1'b0, sel_start_o};
    closes_wide  = !pass_i && open_q && (closed_span >= MIN_W);
    ends_wide    = last_i && pass_i && (running_span >= MIN_W);
    found_o      = closes_wide || ends_wide;
    narrow_o     = last_i && pass_i && (running_span < MIN_W);
  end

  always_comb begin
    open_d  = open_q;
    start_d = start_q;
    stop_d  = stop_q;
    reg_en  = clr_i || upd_i;
    if (clr_i) begin
      open_d  = 1'b0;
      start_d = '0;
      stop_d  = '0;
    end else if (upd_i) begin
      if (pass_i) begin
        open_d = 1'b1;
        if (!open_q) begin
          start_d = tap_i;
        end
        stop_d = tap_i;
      end else begin
        open_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      start_q <= '0;
      stop_q  <= '0;
    end else if (reg_en) begin
      open_q  <= open_d;
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

endmodule

// File: rtl/cdly_seq.sv
// Sweep sequencer: loads taps, runs the two channel tests, decides.
module cdly_seq
  import cdly_pkg::*;
#(
  parameter int TAP_W     = 5,
  parameter int CNT_W     = 8,
  parameter int DWELL_CYC = 8,
  parameter int PAUSE_CYC = 8,
  parameter int MAX_TRIES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             chk_lock_i,
  input  logic             chk_err_i,
  input  logic             tmr_expire_i,
  input  logic             found_i,
  input  logic             narrow_i,
  input  logic [TAP_W-1:0] sel_start_i,
  input  logic [TAP_W-1:0] sel_stop_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             win_clr_o,
  output logic             win_upd_o,
  output logic             tap_pass_o,
  output logic             last_tap_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             dly_load_o,
  output logic             chk_en_o,
  output logic [1:0]       mode_i_o,
  output logic [1:0]       mode_q_o,
  output logic             done_o,
  output logic             fail_conv_o,
  output logic             fail_narrow_o,
  output logic [TAP_W-1:0] result_o
);

  localparam int               ATT_W     = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [ATT_W-1:0] ATT_LAST  = ATT_W'(MAX_TRIES - 1);
  localparam logic [TAP_W-1:0] TAP_LAST  = '1;
  localparam logic [CNT_W-1:0] DWELL_VAL = CNT_W'(DWELL_CYC);
  localparam logic [CNT_W-1:0] PAUSE_VAL = CNT_W'(PAUSE_CYC);

  cal_st_e          state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [ATT_W-1:0] att_q, att_d;
  logic             final_q, final_d;
  logic             done_q, done_d;
  logic             fconv_q, fconv_d;
  logic             fnarr_q, fnarr_d;
  logic [TAP_W-1:0] res_q, res_d;
  logic [NUM_CH-1:0] ch_ok_q, ch_ok_d, cap_en;
  logic [TAP_W:0]   mid_sum;
  logic [TAP_W-1:0] mid_tap;
  logic             res_en;
  logic             ch_sample;

  assign mid_sum    = {1'b0, sel_start_i} + {1'b0, sel_stop_i};
  assign mid_tap    = TAP_W'(mid_sum >> 1);
  assign last_tap_o = (tap_q == TAP_LAST);
  assign tap_pass_o = &ch_ok_q;
  assign ch_sample  = chk_lock_i & ~chk_err_i;

  // One capture flop per channel test.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign ch_ok_d[ch] = cap_en[ch] ? ch_sample : ch_ok_q[ch];
  end

  always_comb begin
    state_d    = state_q;
    tap_d      = tap_q;
    att_d      = att_q;
    final_d    = final_q;
    done_d     = done_q;
    fconv_d    = fconv_q;
    fnarr_d    = fnarr_q;
    res_d      = res_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = DWELL_VAL;
    win_clr_o  = 1'b0;
    win_upd_o  = 1'b0;
    dly_load_o = 1'b0;
    chk_en_o   = 1'b0;
    mode_i_o   = TM_NORMAL;
    mode_q_o   = TM_NORMAL;
    cap_en     = '0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d   = ST_SETV;
          tap_d     = '0;
          att_d     = '0;
          final_d   = 1'b0;
          done_d    = 1'b0;
          fconv_d   = 1'b0;
          fnarr_d   = 1'b0;
          res_d     = '0;
          win_clr_o = 1'b1;
        end
      end
      ST_SETV: state_d = ST_STRB;
      ST_STRB: begin
        dly_load_o = 1'b1;
        if (final_q) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
          res_d   = tap_q;
        end else begin
          state_d = ST_CLR_I;
        end
      end
      ST_CLR_I: begin
        mode_i_o   = TM_RAMP;
        mode_q_o   = TM_ONES;
        tmr_load_o = 1'b1;
        state_d    = ST_DWL_I;
      end
      ST_DWL_I: begin
        mode_i_o = TM_RAMP;
        mode_q_o = TM_ONES;
        chk_en_o = 1'b1;
        if (tmr_expire_i) begin
          cap_en[0] = 1'b1;
          state_d   = ST_CLR_Q;
        end
      end
      ST_CLR_Q: begin
        mode_i_o   = TM_ONES;
        mode_q_o   = TM_RAMP;
        tmr_load_o = 1'b1;
        state_d    = ST_DWL_Q;
      end
      ST_DWL_Q: begin
        mode_i_o = TM_ONES;
        mode_q_o = TM_RAMP;
        chk_en_o = 1'b1;
        if (tmr_expire_i) begin
          cap_en[1] = 1'b1;
          state_d   = ST_EVAL;
        end
      end
      ST_EVAL: begin
        win_upd_o = 1'b1;
        if (found_i) begin
          tap_d   = mid_tap;
          final_d = 1'b1;
          state_d = ST_SETV;
        end else if (last_tap_o) begin
          if (att_q != ATT_LAST) begin
            att_d      = att_q + ATT_W'(1);
            tmr_load_o = 1'b1;
            tmr_val_o  = PAUSE_VAL;
            win_clr_o  = 1'b1;
            state_d    = ST_PAUSE;
          end else begin
            done_d  = 1'b1;
            fnarr_d = narrow_i;
            fconv_d = !narrow_i;
            res_d   = '0;
            state_d = ST_DONE;
          end
        end else begin
          tap_d   = tap_q + TAP_W'(1);
          state_d = ST_SETV;
        end
      end
      ST_PAUSE: begin
        if (tmr_expire_i) begin
          tap_d   = '0;
          state_d = ST_SETV;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign res_en = (done_d != done_q) || (res_d != res_q) ||
                  (fconv_d != fconv_q) || (fnarr_d != fnarr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      att_q   <= '0;
      final_q <= 1'b0;
      ch_ok_q <= '0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
      att_q   <= att_d;
      final_q <= final_d;
      ch_ok_q <= ch_ok_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fconv_q <= 1'b0;
      fnarr_q <= 1'b0;
      res_q   <= '0;
    end else if (res_en) begin
      done_q  <= done_d;
      fconv_q <= fconv_d;
      fnarr_q <= fnarr_d;
      res_q   <= res_d;
    end
  end

  assign tap_o         = tap_q;
  assign done_o        = done_q;
  assign fail_conv_o   = fconv_q;
  assign fail_narrow_o = fnarr_q;
  assign result_o      = res_q;

endmodule

// File: rtl/cdly_cal_ctrl.sv
module cdly_cal_ctrl #(
  parameter int TAP_W     = 5,
  parameter int MIN_SPAN  = 4,
  parameter int DWELL_CYC = 2000,
  parameter int PAUSE_CYC = 20000,
  parameter int MAX_TRIES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [TAP_W-1:0] dly_val_o,
  output logic             dly_load_o,
  output logic             chk_en_o,
  output logic [1:0]       mode_i_o,
  output logic [1:0]       mode_q_o,
  input  logic             chk_lock_i,
  input  logic             chk_err_i,
  output logic             done_o,
  output logic             fail_conv_o,
  output logic             fail_narrow_o,
  output logic [TAP_W-1:0] tap_o
);

  localparam int CNT_MAX = (DWELL_CYC > PAUSE_CYC) ? DWELL_CYC : PAUSE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             tmr_load, tmr_expire;
  logic [CNT_W-1:0] tmr_val;
  logic             win_clr, win_upd, tap_pass, last_tap;
  logic             found, narrow;
  logic [TAP_W-1:0] sel_start, sel_stop, cur_tap;

  cdly_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (tmr_expire)
  );

  cdly_window #(.TAP_W(TAP_W), .MIN_SPAN(MIN_SPAN)) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (win_clr),
    .upd_i       (win_upd),
    .pass_i      (tap_pass),
    .last_i      (last_tap),
    .tap_i       (cur_tap),
    .found_o     (found),
    .narrow_o    (narrow),
    .sel_start_o (sel_start),
    .sel_stop_o  (sel_stop)
  );

  cdly_seq #(
    .TAP_W     (TAP_W),
    .CNT_W     (CNT_W),
    .DWELL_CYC (DWELL_CYC),
    .PAUSE_CYC (PAUSE_CYC),
    .MAX_TRIES (MAX_TRIES)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .chk_lock_i    (chk_lock_i),
    .chk_err_i     (chk_err_i),
    .tmr_expire_i  (tmr_expire),
    .found_i       (found),
    .narrow_i      (narrow),
    .sel_start_i   (sel_start),
    .sel_stop_i    (sel_stop),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .win_clr_o     (win_clr),
    .win_upd_o     (win_upd),
    .tap_pass_o    (tap_pass),
    .last_tap_o    (last_tap),
    .tap_o         (cur_tap),
    .dly_load_o    (dly_load_o),
    .chk_en_o      (chk_en_o),
    .mode_i_o      (mode_i_o),
    .mode_q_o      (mode_q_o),
    .done_o        (done_o),
    .fail_conv_o   (fail_conv_o),
    .fail_narrow_o (fail_narrow_o),
    .result_o      (tap_o)
  );

  assign dly_val_o = cur_tap;

endmodule

// File: rtl/cdly_cal_ctrl_chk.sv
module cdly_cal_ctrl_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAP_W-1:0] dly_val_o,
  input logic             dly_load_o,
  input logic             chk_en_o,
  input logic [1:0]       mode_i_o,
  input logic [1:0]       mode_q_o,
  input logic             done_o,
  input logic             fail_conv_o,
  input logic             fail_narrow_o,
  input logic [TAP_W-1:0] tap_o
);

  // R2: strobe lasts one cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    dly_load_o |=> !dly_load_o);

  // R2: value already present the cycle before the strobe
  a_r2_value_settled: assert property (@(posedge clk) disable iff (!rst_n)
    dly_load_o |-> $stable(dly_val_o));

  // R3: checker only runs with one channel on ramp and the other on ones
  a_r3_enabled_modes: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_o |-> ((mode_i_o == 2'd1 && mode_q_o == 2'd2) ||
                  (mode_i_o == 2'd2 && mode_q_o == 2'd1)));

  // R3: enable rises only after a clear cycle in the same modes
  a_r3_clear_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_en_o) |-> ($past(mode_i_o) == mode_i_o && $past(mode_q_o) == mode_q_o));

  // R9: finished means normal modes, checker off, no strobe
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!chk_en_o && !dly_load_o && mode_i_o == 2'd0 && mode_q_o == 2'd0));

  // R10: failure flags exclusive, only when done, tap reported as zero
  a_r10_fail_report: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_conv_o || fail_narrow_o) |->
      (done_o && !(fail_conv_o && fail_narrow_o) && tap_o == '0));

  // R8: reported tap is the one last loaded into the delay line
  a_r8_tap_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fail_conv_o && !fail_narrow_o) |-> (tap_o == dly_val_o));

endmodule

bind cdly_cal_ctrl cdly_cal_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dly_val_o     (dly_val_o),
  .dly_load_o    (dly_load_o),
  .chk_en_o      (chk_en_o),
  .mode_i_o      (mode_i_o),
  .mode_q_o      (mode_q_o),
  .done_o        (done_o),
  .fail_conv_o   (fail_conv_o),
  .fail_narrow_o (fail_narrow_o),
  .tap_o         (tap_o)
);

// File: tb/cdly_cal_ctrl_bench.sv
module cdly_cal_ctrl_bench;

  localparam int TAP_W = 5;
  localparam int DWELL = 3;
  localparam int PAUSE = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, start_i;
  logic [TAP_W-1:0] dly_val_o, tap_o;
  logic             dly_load_o, chk_en_o, done_o, fail_conv_o, fail_narrow_o;
  logic [1:0]       mode_i_o, mode_q_o;
  logic             chk_lock_i, chk_err_i;

  // Fault masks per attempt [att][channel], bit = tap.
  logic [31:0] err_m [2][2];
  logic [31:0] nl_m  [2][2];
  int cur_att = 0;

  int n_checks = 0, n_errs = 0;
  bit finished = 0;

  logic test_q;
  assign test_q     = (mode_q_o == 2'd1);
  assign chk_lock_i = chk_en_o && !nl_m[cur_att][test_q][dly_val_o];
  assign chk_err_i  = chk_en_o && err_m[cur_att][test_q][dly_val_o];

  cdly_cal_ctrl #(
    .TAP_W(TAP_W), .MIN_SPAN(4), .DWELL_CYC(DWELL), .PAUSE_CYC(PAUSE), .MAX_TRIES(2)
  ) u_cdly_cal_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dly_val_o(dly_val_o), .dly_load_o(dly_load_o), .chk_en_o(chk_en_o),
    .mode_i_o(mode_i_o), .mode_q_o(mode_q_o),
    .chk_lock_i(chk_lock_i), .chk_err_i(chk_err_i),
    .done_o(done_o), .fail_conv_o(fail_conv_o), .fail_narrow_o(fail_narrow_o),
    .tap_o(tap_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor state
  bit mon_on = 0;
  int loads, zero_loads, nonseq, last_load, gap_idle, i_cyc, q_cyc;
  bit order_bad;
  logic [TAP_W-1:0] prev_val;

  task automatic dwell_check();
    check(i_cyc == DWELL && q_cyc == DWELL && !order_bad, "R3 I-then-Q dwell (i*100+q)",
          i_cyc * 100 + q_cyc, DWELL * 100 + DWELL);
    i_cyc = 0; q_cyc = 0; order_bad = 0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (!chk_en_o) gap_idle++;
      if (chk_en_o && mode_i_o == 2'd1) begin
        if (q_cyc > 0) order_bad = 1;
        i_cyc++;
      end
      if (chk_en_o && mode_q_o == 2'd1) q_cyc++;
      if (dly_load_o) begin
        check(dly_val_o == prev_val, "R2 value presented before strobe", int'(dly_val_o), int'(prev_val));
        if (i_cyc + q_cyc > 0) dwell_check();
        if (dly_val_o == '0) begin
          if (zero_loads > 0) check(gap_idle == PAUSE + 3, "R7 retry pause length", gap_idle, PAUSE + 3);
          zero_loads++;
          cur_att = (zero_loads > 1) ? 1 : 0;
        end else if (int'(dly_val_o) != last_load + 1) begin
          nonseq++;
        end
        last_load = int'(dly_val_o);
        loads++;
      end
      if (chk_en_o) gap_idle = 0;
    end
    prev_val = dly_val_o;
  end

  function automatic logic [31:0] span(input int lo, input int hi);
    logic [31:0] m = '0;
    for (int t = lo; t <= hi; t++) m[t] = 1'b1;
    return m;
  endfunction

  task automatic clear_masks();
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 2; c++) begin
        err_m[a][c] = '0;
        nl_m[a][c]  = '0;
      end
  endtask

  // Reference search built from R4..R7 and R10.
  task automatic model(output int tap, output int conv, output int narr,
                       output int tries, output int visited);
    logic [31:0] ok;
    bit open, found;
    int s, e;
    tap = 0; conv = 0; narr = 0; tries = 0; visited = 0;
    for (int a = 0; a < 2; a++) begin
      ok = ~(err_m[a][0] | err_m[a][1] | nl_m[a][0] | nl_m[a][1]);
      open = 0; found = 0; s = 0; e = 0;
      tries = a + 1;
      for (int t = 0; t < 32 && !found; t++) begin
        visited++;
        if (ok[t]) begin
          if (!open) begin open = 1; s = t; end
          e = t;
        end else if (open) begin
          if (e - s >= 4) found = 1;
          else open = 0;
        end
      end
      if (!found && open && e - s >= 4) found = 1;
      if (found) begin
        tap = (s + e) / 2;
        return;
      end
      if (a == 1) begin
        if (open) narr = 1;
        else conv = 1;
      end
    end
  endtask

  task automatic run_case(input string req);
    int et, ec, en, etr, ev, k, poke, succ;
    model(et, ec, en, etr, ev);
    succ = (ec == 0 && en == 0) ? 1 : 0;
    loads = 0; zero_loads = 0; nonseq = 0; last_load = 0; gap_idle = 0;
    i_cyc = 0; q_cyc = 0; order_bad = 0; cur_att = 0;
    mon_on = 1;
    poke = 2 + int'($urandom_range(0, 30));
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    k = 0;
    // R11: a second start pulse lands mid-search
    while (!done_o && k < 5000) begin
      @(negedge clk);
      k++;
      start_i = (k == poke);
    end
    start_i = 1'b0;
    check(k < 5000, {req, " search completes"}, k, 5000);
    repeat (3) @(negedge clk);
    if (i_cyc + q_cyc > 0) dwell_check();
    mon_on = 0;
    check(done_o == 1'b1, "R9 done held", int'(done_o), 1);
    check(!chk_en_o && mode_i_o == 2'd0 && mode_q_o == 2'd0, "R9 normal modes and checker off",
          int'({chk_en_o, mode_i_o, mode_q_o}), 0);
    check(int'(tap_o) == et, {req, " R11 chosen tap"}, int'(tap_o), et);
    check(int'(fail_conv_o) == ec, "R10 convergence flag", int'(fail_conv_o), ec);
    check(int'(fail_narrow_o) == en, "R10 narrow flag", int'(fail_narrow_o), en);
    check(zero_loads == etr, "R7 sweep count", zero_loads, etr);
    check(nonseq == succ, "R8 midpoint load count", nonseq, succ);
    check(loads == ev + succ, "R5 R2 loads until stop", loads, ev + succ);
  endtask

  // Global watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0d_5eed));
    clear_masks();
    rst_n = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({done_o, fail_conv_o, fail_narrow_o, dly_load_o, chk_en_o} == 5'b0, "R1 flags in reset",
          int'({done_o, fail_conv_o, fail_narrow_o, dly_load_o, chk_en_o}), 0);
    check(dly_val_o == '0 && tap_o == '0 && mode_i_o == 2'd0 && mode_q_o == 2'd0, "R1 values in reset",
          int'({dly_val_o, tap_o, mode_i_o, mode_q_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({done_o, dly_load_o, chk_en_o} == 3'b0, "R1 idle after release",
          int'({done_o, dly_load_o, chk_en_o}), 0);

    // R6: all pass, window reaches the top tap
    clear_masks();
    run_case("R6 all pass");

    // R5: window 3..10 closed by a failing tap
    clear_masks();
    err_m[0][0] = ~span(3, 10);
    run_case("R5 closed window");

    // R5: span 3 discarded, span exactly 4 accepted
    clear_masks();
    err_m[0][1] = ~(span(3, 6) | span(10, 14));
    run_case("R5 span boundary");

    // R4: missing lock on Q alone breaks the window
    clear_masks();
    nl_m[0][1][8] = 1'b1;
    run_case("R4 Q lock lost");

    // R4: I error alone breaks the window
    clear_masks();
    err_m[0][0][2] = 1'b1;
    err_m[0][0][9] = 1'b1;
    run_case("R4 I error");

    // R7: first sweep fails, second finds 20..31
    clear_masks();
    err_m[0][0] = '1;
    err_m[1][1] = ~span(20, 31);
    run_case("R7 retry succeeds");

    // R10: nothing passes in either sweep
    clear_masks();
    nl_m[0][0] = '1;
    nl_m[1][1] = '1;
    run_case("R10 no window");

    // R10: narrow window at the top in the final sweep
    clear_masks();
    err_m[0][0] = ~span(29, 31);
    err_m[1][0] = ~span(28, 31);
    run_case("R10 narrow at top");

    // R6: wide window ending exactly at the top
    clear_masks();
    err_m[0][1] = ~span(27, 31);
    run_case("R6 top window span 4");

    // Random fault patterns
    for (int n = 0; n < 20; n++) begin
      for (int a = 0; a < 2; a++)
        for (int c = 0; c < 2; c++) begin
          err_m[a][c] = $urandom & $urandom & $urandom;
          nl_m[a][c]  = $urandom & $urandom & $urandom & $urandom;
        end
      if ($urandom_range(0, 3) == 0) err_m[0][0] = '1;
      run_case("R5 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule